// File: doc/BRIEF.md
# Video-Mode Line and Frame Sequencer

This block produces the horizontal and vertical timing skeleton of a serial display link that streams pixels in video mode. Once enabled, it counts byte-clock cycles within a line and lines within a frame. At every cycle it reports which vertical region and which horizontal region the link is in. It also says whether the lanes may drop to low power, and it raises a one-cycle request whenever a sync, video or filler packet has to start.

All durations come from static configuration words. Vertical blanking counts are packed into one word, and the two horizontal blanking times share another. The packet size and the chunk count share a third. The active payload of a line can be sent as one packet, or split into several equal chunks, each followed by a filler packet. The surrounding transmitter uses the requests and region codes to schedule packets and lane power states. Configuration may only change while `enable` is low.

Top module: `vid_line_frame_seq`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `enable` low, `running`, `pkt_req`, `lp_ok` and `line_start` are 0, and `vregion`, `hregion`, `pkt_kind`, `chunk_idx`, `line_cnt` and `frame_cnt` are 0.
- R2: The first cycle with `running` high is cycle 0 of line 0 of frame 0, and `line_start` is high there. Each line lasts `cfg_line_len` cycles, with a value of 0 taken as 1, and `line_start` is high in the first cycle of every line.
- R3: Line counts come from `cfg_vblank`: sync in bits [29:20], back porch in [19:10], front porch in [9:0]. Active lines come from `cfg_vact`. Each frame runs sync(`vregion`=0), back porch(1), active(2), front porch(3), and a region with a count of 0 is skipped. A frame with no lines at all has one front-porch line. `frame_cnt` increments after the last line of each frame and wraps.
- R4: Within each line, the first `cfg_delay` cycles are remaining time (`hregion`=3). Next comes the sync region (`hregion`=0). It lasts `cfg_hblank[31:16]` cycles (at least 1) when `cfg_mode[1:0]` is 0, 2 or 3, and exactly 1 cycle when it is 1. Then the back porch (`hregion`=1) lasts `cfg_hblank[15:0]` cycles.
- R5: A request with `pkt_kind`=0 (sync) is raised in the first sync-region cycle of every line.
- R6: In active lines only, the payload (`hregion`=2) follows the back porch. Each chunk starts with a request of `pkt_kind`=1 and carries `cfg_pkt[15:0]` cycles of video (at least 1). `chunk_idx` gives the chunk number from 0 during the payload and is 0 elsewhere.
- R7: When `cfg_pkt[31:16]` is 2 or more and the mode is 0 or 1, that many chunks are sent. Each chunk is followed by a filler of the null-size cycles, which starts with a request of `pkt_kind`=2. A null size of 0 gives back-to-back chunks with no filler requests.
- R8: In burst mode (`cfg_mode[1:0]` of 2 or 3), or with a chunk count of 0 or 1, the payload is a single chunk with no filler.
- R9: A `cfg_null` value above 1023 acts as 1023.
- R10: After the last chunk, the line is remaining time (`hregion`=3) until it ends. A payload that does not fit is cut off at the end of the line, and the next line starts normally.
- R11: `lp_ok` is high only in back-porch or remaining-time cycles where the enable bit of `cfg_mode` for the current region is set and no request is raised. The bits are: 8 vertical sync, 9 vertical back porch, 10 vertical front porch, 11 active lines, 12 horizontal back porch, 13 horizontal remaining time. In active lines, both bit 11 and the horizontal bit must be set. In blanking lines, only the vertical bit counts.
- R12: `line_cnt` gives the line number within the frame, from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the sequencer; low clears all counters |
| cfg_vblank | input | 32 | Packed vertical sync, back-porch and front-porch line counts |
| cfg_hblank | input | 32 | Horizontal sync time [31:16], back-porch time [15:0] |
| cfg_line_len | input | LT_W | Total line time in byte cycles |
| cfg_vact | input | VACT_W | Number of active lines |
| cfg_mode | input | 32 | Mode [1:0], low-power enables [13:8] |
| cfg_pkt | input | 32 | Chunk count [31:16], video packet size [15:0] |
| cfg_null | input | 16 | Filler size in cycles, saturates at 1023 |
| cfg_delay | input | DLY_W | Cycles from line start to the sync region |
| running | output | 1 | Sequencer active |
| vregion | output | 2 | Vertical region code |
| hregion | output | 2 | Horizontal region code |
| lp_ok | output | 1 | Lanes may enter low power |
| pkt_req | output | 1 | One-cycle packet start request |
| pkt_kind | output | 2 | 0 sync, 1 video, 2 filler |
| chunk_idx | output | 16 | Current chunk number in the payload |
| line_start | output | 1 | First cycle of a line |
| line_cnt | output | LN_W | Line number within the frame |
| frame_cnt | output | FRM_W | Frame counter, wrapping |

## Verification
A corrupted position counter shifts every horizontal boundary and the sync request within the same line, so `hregion` and `pkt_req` disagree with the reference model in the cycle the state goes wrong. A wrong line index shows on `line_cnt` and `vregion` at once. A fault in the chunk counters changes the request pattern, `chunk_idx` or the end of the payload within one segment. The bench therefore compares every output against a behavioural model on every cycle. The configurations cover each mode, the chunk-count corners, filler saturation, payload cut-off and zero-length lines.

// File: rtl/vsq_pkg.sv
package vsq_pkg;

  // fixed field placement inside the packed configuration words
  localparam int VB_W    = 10;
  localparam int VFP_LSB = 0;
  localparam int VBP_LSB = 10;
  localparam int VSA_LSB = 20;
  localparam int HF_W    = 16;
  localparam int HBP_LSB = 0;
  localparam int HSA_LSB = 16;
  localparam int PKT_LSB = 0;
  localparam int CHN_LSB = 16;
  localparam int LP_LSB  = 8;
  localparam int LP_N    = 6;
  localparam int NUL_W   = 10;
  localparam int NUL_MAX = 1023;

  typedef enum logic [1:0] {
    V_SYNC  = 2'd0,
    V_BACK  = 2'd1,
    V_ACT   = 2'd2,
    V_FRONT = 2'd3
  } vreg_e;

  typedef enum logic [1:0] {
    H_SYNC = 2'd0,
    H_BACK = 2'd1,
    H_PAY  = 2'd2,
    H_REM  = 2'd3
  } hreg_e;

  typedef enum logic [1:0] {
    PK_SYNC  = 2'd0,
    PK_VIDEO = 2'd1,
    PK_NULL  = 2'd2
  } pkind_e;

  // lp enable index
  localparam int LPI_VSA = 0;
  localparam int LPI_VBP = 1;
  localparam int LPI_VFP = 2;
  localparam int LPI_VAC = 3;
  localparam int LPI_HBP = 4;
  localparam int LPI_HRM = 5;

  typedef struct packed {
    logic [VB_W-1:0]  vsa;
    logic [VB_W-1:0]  vbp;
    logic [VB_W-1:0]  vfp;
    logic [HF_W-1:0]  hsa;
    logic [HF_W-1:0]  hbp;
    logic [HF_W-1:0]  pkt;
    logic [HF_W-1:0]  chunks;
    logic [NUL_W-1:0] nul;
    logic [LP_N-1:0]  lp;
    logic             burst;
  } tcfg_t;

endpackage

// File: rtl/vsq_rst_sync.sv
module vsq_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign srst_n = stage_q[1];

endmodule

// File: rtl/vsq_cfg_unpack.sv
module vsq_cfg_unpack
  import vsq_pkg::*;
(
  input  logic [31:0] vblank_w,
  input  logic [31:0] hblank_w,
  input  logic [31:0] mode_w,
  input  logic [31:0] pkt_w,
  input  logic [15:0] null_w,
  output tcfg_t       cfg
);

  logic [1:0]      mode;
  logic [HF_W-1:0] hsa_raw;
  logic [HF_W-1:0] pkt_raw;
  logic [HF_W-1:0] chn_raw;
  logic            single;

  always_comb begin
    mode    = mode_w[1:0];
    hsa_raw = hblank_w[HSA_LSB +: HF_W];
    pkt_raw = pkt_w[PKT_LSB +: HF_W];
    chn_raw = pkt_w[CHN_LSB +: HF_W];
    single  = mode[1] || (chn_raw < HF_W'(2));

    cfg.vsa   = vblank_w[VSA_LSB +: VB_W];
    cfg.vbp   = vblank_w[VBP_LSB +: VB_W];
    cfg.vfp   = vblank_w[VFP_LSB +: VB_W];
    cfg.hbp   = hblank_w[HBP_LSB +: HF_W];
    cfg.lp    = mode_w[LP_LSB +: LP_N];
    cfg.burst = mode[1];

    if (mode == 2'd1) begin
      cfg.hsa = HF_W'(1);
    end else if (hsa_raw == '0) begin
      cfg.hsa = HF_W'(1);
    end else begin
      cfg.hsa = hsa_raw;
    end

    cfg.pkt    = (pkt_raw == '0) ? HF_W'(1) : pkt_raw;
    cfg.chunks = single ? HF_W'(1) : chn_raw;

    if (single) begin
      cfg.nul = '0;
    end else if (null_w > 16'(NUL_MAX)) begin
      cfg.nul = NUL_W'(NUL_MAX);
    end else begin
      cfg.nul = null_w[NUL_W-1:0];
    end
  end

endmodule

// File: rtl/vsq_line_timer.sv
module vsq_line_timer #(
  parameter int LT_W  = 24,
  parameter int LN_W  = 14,
  parameter int FRM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [LT_W-1:0]  lt_eff,
  input  logic [LN_W-1:0]  total,
  output logic             run,
  output logic [LT_W-1:0]  pos,
  output logic [LN_W-1:0]  line,
  output logic [FRM_W-1:0] frame,
  output logic             wrap
);

  logic             run_d;
  logic [LT_W-1:0]  pos_d;
  logic [LN_W-1:0]  line_d;
  logic [FRM_W-1:0] frame_d;
  logic             last_line;

  assign wrap      = run && (pos == lt_eff - LT_W'(1));
  assign last_line = (line == total - LN_W'(1));

  always_comb begin
    run_d   = enable;
    pos_d   = pos;
    line_d  = line;
    frame_d = frame;
    if (!enable || !run) begin
      pos_d   = '0;
      line_d  = '0;
      frame_d = enable ? frame : '0;
    end else if (wrap) begin
      pos_d = '0;
      if (last_line) begin
        line_d  = '0;
        frame_d = frame + FRM_W'(1);
      end else begin
        line_d = line + LN_W'(1);
      end
    end else begin
      pos_d = pos + LT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run   <= 1'b0;
      pos   <= '0;
      line  <= '0;
      frame <= '0;
    end else begin
      run   <= run_d;
      pos   <= pos_d;
      line  <= line_d;
      frame <= frame_d;
    end
  end

  // R2
  pos_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (pos < lt_eff));

  // R2
  pos_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && pos != '0) |-> (pos == $past(pos) + LT_W'(1)));

  // R12
  line_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (line < total));

endmodule

// File: rtl/vsq_payload.sv
module vsq_payload #(
  parameter int SEG_W = 17,
  parameter int CH_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  input  logic [SEG_W-1:0] seg_len,
  input  logic [CH_W-1:0]  chunks,
  output logic [SEG_W-1:0] seg_pos,
  output logic [CH_W-1:0]  chunk,
  output logic             done
);

  logic [SEG_W-1:0] seg_pos_d;
  logic [CH_W-1:0]  chunk_d;
  logic             done_d;
  logic             seg_end;

  assign seg_end = (seg_pos == seg_len - SEG_W'(1));

  always_comb begin
    seg_pos_d = seg_pos;
    chunk_d   = chunk;
    done_d    = done;
    if (clr) begin
      seg_pos_d = '0;
      chunk_d   = '0;
      done_d    = 1'b0;
    end else if (adv) begin
      if (seg_end) begin
        seg_pos_d = '0;
        chunk_d   = chunk + CH_W'(1);
        done_d    = (chunk + CH_W'(1) == chunks);
      end else begin
        seg_pos_d = seg_pos + SEG_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_pos <= '0;
      chunk   <= '0;
      done    <= 1'b0;
    end else begin
      seg_pos <= seg_pos_d;
      chunk   <= chunk_d;
      done    <= done_d;
    end
  end

  // R6
  chunk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (chunk < chunks));

  // R7
  seg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> (seg_pos < seg_len));

endmodule

// File: rtl/vid_line_frame_seq.sv
module vid_line_frame_seq
  import vsq_pkg::*;
#(
  parameter int LT_W   = 24,
  parameter int DLY_W  = 24,
  parameter int VACT_W = 12,
  parameter int FRM_W  = 8,
  localparam int LN_W  = ((VACT_W > VB_W) ? VACT_W : VB_W) + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [31:0]       cfg_vblank,
  input  logic [31:0]       cfg_hblank,
  input  logic [LT_W-1:0]   cfg_line_len,
  input  logic [VACT_W-1:0] cfg_vact,
  input  logic [31:0]       cfg_mode,
  input  logic [31:0]       cfg_pkt,
  input  logic [15:0]       cfg_null,
  input  logic [DLY_W-1:0]  cfg_delay,
  output logic              running,
  output logic [1:0]        vregion,
  output logic [1:0]        hregion,
  output logic              lp_ok,
  output logic              pkt_req,
  output logic [1:0]        pkt_kind,
  output logic [15:0]       chunk_idx,
  output logic              line_start,
  output logic [LN_W-1:0]   line_cnt,
  output logic [FRM_W-1:0]  frame_cnt
);

  localparam int THR_W = ((DLY_W > LT_W) ? DLY_W : LT_W) + 2;
  localparam int SEG_W = HF_W + 1;

  logic             srst_n;
  tcfg_t            cfg;
  logic             run;
  logic [LT_W-1:0]  pos;
  logic [LN_W-1:0]  line;
  logic [FRM_W-1:0] frame;
  logic             wrap;
  logic [LT_W-1:0]  lt_eff;
  logic [LN_W-1:0]  v_b1, v_b2, v_b3, tot_raw, total;
  logic [THR_W-1:0] p_ext, t_sync, t_bp, t_pay;
  logic [SEG_W-1:0] seg_len, seg_pos;
  logic [HF_W-1:0]  chunk;
  logic             pay_done;
  vreg_e            vreg;
  hreg_e            hreg;
  logic             sync_req, vid_req, nul_req;
  logic             lp_en;

  vsq_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  vsq_cfg_unpack u_cfg (
    .vblank_w (cfg_vblank),
    .hblank_w (cfg_hblank),
    .mode_w   (cfg_mode),
    .pkt_w    (cfg_pkt),
    .null_w   (cfg_null),
    .cfg      (cfg)
  );

  // frame and line geometry
  always_comb begin
    lt_eff  = (cfg_line_len == '0) ? LT_W'(1) : cfg_line_len;
    v_b1    = LN_W'(cfg.vsa);
    v_b2    = v_b1 + LN_W'(cfg.vbp);
    v_b3    = v_b2 + LN_W'(cfg_vact);
    tot_raw = v_b3 + LN_W'(cfg.vfp);
    total   = (tot_raw == '0) ? LN_W'(1) : tot_raw;
    t_sync  = THR_W'(cfg_delay);
    t_bp    = t_sync + THR_W'(cfg.hsa);
    t_pay   = t_bp + THR_W'(cfg.hbp);
    seg_len = SEG_W'(cfg.pkt) + SEG_W'(cfg.nul);
  end

  vsq_line_timer #(
    .LT_W  (LT_W),
    .LN_W  (LN_W),
    .FRM_W (FRM_W)
  ) u_timer (
    .clk    (clk),
    .rst_n  (srst_n),
    .enable (enable),
    .lt_eff (lt_eff),
    .total  (total),
    .run    (run),
    .pos    (pos),
    .line   (line),
    .frame  (frame),
    .wrap   (wrap)
  );

  assign p_ext = THR_W'(pos);

  // region decode
  always_comb begin
    if (line < v_b1) begin
      vreg = V_SYNC;
    end else if (line < v_b2) begin
      vreg = V_BACK;
    end else if (line < v_b3) begin
      vreg = V_ACT;
    end else begin
      vreg = V_FRONT;
    end

    if (p_ext < t_sync) begin
      hreg = H_REM;
    end else if (p_ext < t_bp) begin
      hreg = H_SYNC;
    end else if (p_ext < t_pay) begin
      hreg = H_BACK;
    end else if (vreg == V_ACT && !pay_done) begin
      hreg = H_PAY;
    end else begin
      hreg = H_REM;
    end
  end

  vsq_payload #(
    .SEG_W (SEG_W),
    .CH_W  (HF_W)
  ) u_pay (
    .clk     (clk),
    .rst_n   (srst_n),
    .clr     (!run || wrap),
    .adv     (run && hreg == H_PAY),
    .seg_len (seg_len),
    .chunks  (cfg.chunks),
    .seg_pos (seg_pos),
    .chunk   (chunk),
    .done    (pay_done)
  );

  // packet requests
  always_comb begin
    sync_req = run && (p_ext == t_sync);
    vid_req  = run && (hreg == H_PAY) && (seg_pos == '0);
    nul_req  = run && (hreg == H_PAY) && (cfg.nul != '0) &&
               (seg_pos == SEG_W'(cfg.pkt));
  end

  // low-power permission per region
  always_comb begin
    lp_en = 1'b0;
    unique case (vreg)
      V_SYNC:  lp_en = cfg.lp[LPI_VSA];
      V_BACK:  lp_en = cfg.lp[LPI_VBP];
      V_FRONT: lp_en = cfg.lp[LPI_VFP];
      V_ACT:   lp_en = cfg.lp[LPI_VAC] &&
                       ((hreg == H_BACK) ? cfg.lp[LPI_HBP] : cfg.lp[LPI_HRM]);
      default: lp_en = 1'b0;
    endcase
  end

  // outputs
  always_comb begin
    running    = run;
    vregion    = run ? vreg : 2'd0;
    hregion    = run ? hreg : 2'd0;
    pkt_req    = sync_req || vid_req || nul_req;
    if (sync_req) begin
      pkt_kind = PK_SYNC;
    end else if (vid_req) begin
      pkt_kind = PK_VIDEO;
    end else if (nul_req) begin
      pkt_kind = PK_NULL;
    end else begin
      pkt_kind = 2'd0;
    end
    lp_ok      = run && (hreg == H_BACK || hreg == H_REM) && lp_en && !pkt_req;
    chunk_idx  = (run && hreg == H_PAY) ? chunk : 16'd0;
    line_start = run && (pos == '0);
    line_cnt   = line;
    frame_cnt  = frame;
  end

  // R11
  lp_quiet_chk: assert property (@(posedge clk) disable iff (!srst_n)
    pkt_req |-> !lp_ok);

  // R6
  pay_in_vact_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (hregion == H_PAY) |-> (vregion == V_ACT));

  // R8
  null_gate_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (pkt_req && pkt_kind == PK_NULL) |-> (!cfg_mode[1] && cfg_pkt[31:16] >= 16'd2));

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !running |-> (!pkt_req && !lp_ok && !line_start));

  // R5
  sync_once_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (pkt_req && pkt_kind == PK_SYNC) |-> (hregion == H_SYNC));

endmodule

// File: tb/vid_line_frame_seq_tb_top.sv
module vid_line_frame_seq_tb_top;

  localparam int LT_W = 24, DLY_W = 24, VACT_W = 12, FRM_W = 8;
  localparam int LN_W = 14;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              enable = 1'b0;
  logic [31:0]       cfg_vblank = '0, cfg_hblank = '0, cfg_mode = '0, cfg_pkt = '0;
  logic [LT_W-1:0]   cfg_line_len = '0;
  logic [VACT_W-1:0] cfg_vact = '0;
  logic [15:0]       cfg_null = '0;
  logic [DLY_W-1:0]  cfg_delay = '0;
  logic              running, lp_ok, pkt_req, line_start;
  logic [1:0]        vregion, hregion, pkt_kind;
  logic [15:0]       chunk_idx;
  logic [LN_W-1:0]   line_cnt;
  logic [FRM_W-1:0]  frame_cnt;

  int errors = 0;
  int checks = 0;
  string tag = "R1";
  bit done = 0;

  int m_run = 0, m_pos = 0, m_li = 0, m_frame = 0;

  always #2 clk = ~clk;

  vid_line_frame_seq dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_vblank(cfg_vblank), .cfg_hblank(cfg_hblank), .cfg_line_len(cfg_line_len),
    .cfg_vact(cfg_vact), .cfg_mode(cfg_mode), .cfg_pkt(cfg_pkt), .cfg_null(cfg_null),
    .cfg_delay(cfg_delay), .running(running), .vregion(vregion), .hregion(hregion),
    .lp_ok(lp_ok), .pkt_req(pkt_req), .pkt_kind(pkt_kind), .chunk_idx(chunk_idx),
    .line_start(line_start), .line_cnt(line_cnt), .frame_cnt(frame_cnt)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s (%s) at %0t: actual=%0d expected=%0d", req, what, tag, $time, act, exp);
    end
  endtask

  // behavioural reference, evaluated between clock edges
  always @(negedge clk) begin
    int vsa, vbp, vfp, vac, tot, lt, mode, hsa, hbp, dly, pk, ch, nch, nul, seg;
    int vr, hr, req, kind, chn, lp, a, q, k, r, en;
    if (!done) begin
      vsa = int'(cfg_vblank[29:20]); vbp = int'(cfg_vblank[19:10]); vfp = int'(cfg_vblank[9:0]);
      vac = int'(cfg_vact);
      tot = vsa + vbp + vac + vfp; if (tot == 0) tot = 1;
      lt = int'(cfg_line_len); if (lt == 0) lt = 1;
      mode = int'(cfg_mode[1:0]);
      hsa = int'(cfg_hblank[31:16]); if (hsa == 0 || mode == 1) hsa = 1;
      hbp = int'(cfg_hblank[15:0]);
      dly = int'(cfg_delay);
      pk = int'(cfg_pkt[15:0]); if (pk == 0) pk = 1;
      ch = int'(cfg_pkt[31:16]);
      if (mode >= 2 || ch <= 1) begin nch = 1; nul = 0; end
      else begin nch = ch; nul = int'(cfg_null); if (nul > 1023) nul = 1023; end
      seg = pk + nul;
      vr = 0; hr = 0; req = 0; kind = 0; chn = 0; lp = 0;
      if (m_run != 0) begin
        if (m_li < vsa) vr = 0;
        else if (m_li < vsa + vbp) vr = 1;
        else if (m_li < vsa + vbp + vac) vr = 2;
        else vr = 3;
        a = dly + hsa + hbp;
        if (m_pos < dly) hr = 3;
        else if (m_pos < dly + hsa) hr = 0;
        else if (m_pos < a) hr = 1;
        else begin
          hr = 3;
          if (vr == 2) begin
            q = m_pos - a; k = q / seg; r = q % seg;
            if (k < nch) begin
              hr = 2; chn = k;
              if (r == 0) begin req = 1; kind = 1; end
              else if (nul > 0 && r == pk) begin req = 1; kind = 2; end
            end
          end
        end
        if (m_pos == dly) begin req = 1; kind = 0; end
        if (hr == 1 || hr == 3) begin
          if (vr == 2) en = (cfg_mode[11] && (hr == 1 ? cfg_mode[12] : cfg_mode[13])) ? 1 : 0;
          else if (vr == 0) en = cfg_mode[8] ? 1 : 0;
          else if (vr == 1) en = cfg_mode[9] ? 1 : 0;
          else en = cfg_mode[10] ? 1 : 0;
          lp = (en != 0 && req == 0) ? 1 : 0;
        end
      end
      chk("R1", "running", longint'(running), m_run);
      chk("R2", "line_start", longint'(line_start), (m_run != 0 && m_pos == 0) ? 1 : 0);
      chk("R3", "vregion", longint'(vregion), vr);
      chk("R4", "hregion", longint'(hregion), hr);
      chk("R5/R6/R7", "pkt_req", longint'(pkt_req), req);
      chk("R5/R6/R7", "pkt_kind", longint'(pkt_kind), kind);
      chk("R6", "chunk_idx", longint'(chunk_idx), chn);
      chk("R11", "lp_ok", longint'(lp_ok), lp);
      chk("R12", "line_cnt", longint'(line_cnt), m_li);
      chk("R3", "frame_cnt", longint'(frame_cnt), m_frame);
      // predict the state after the coming edge
      if (!rst_n || !enable) begin
        m_run = 0; m_pos = 0; m_li = 0; m_frame = 0;
      end else if (m_run == 0) begin
        m_run = 1; m_pos = 0; m_li = 0;
      end else if (m_pos == lt - 1) begin
        m_pos = 0;
        if (m_li == tot - 1) begin m_li = 0; m_frame = (m_frame + 1) % 256; end
        else m_li = m_li + 1;
      end else begin
        m_pos = m_pos + 1;
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic run_cfg(string t, logic [31:0] vb, logic [VACT_W-1:0] va, logic [31:0] hb,
                         int ll, int dl, logic [31:0] md, logic [31:0] pw, logic [15:0] nl,
                         int n);
    tag = t;
    cfg_vblank = vb; cfg_vact = va; cfg_hblank = hb; cfg_line_len = LT_W'(ll);
    cfg_delay = DLY_W'(dl); cfg_mode = md; cfg_pkt = pw; cfg_null = nl;
    cycles(1);
    enable = 1'b1;
    cycles(n);
    enable = 1'b0;
    cycles(3);
  endtask

  function automatic logic [31:0] vbw(int sa, int bp, int fp);
    return {2'b00, 10'(sa), 10'(bp), 10'(fp)};
  endfunction

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(5);
    // R1 reset state seen at the ports
    chk("R1", "running after reset", longint'(running), 0);
    chk("R1", "line_cnt after reset", longint'(line_cnt), 0);
    chk("R1", "pkt_req after reset", longint'(pkt_req), 0);

    // R3 R4 R7: pulses mode, three chunks with filler; directed frame count
    tag = "R3 chunked";
    cfg_vblank = vbw(1, 1, 1); cfg_vact = 12'd2; cfg_hblank = {16'd3, 16'd2};
    cfg_line_len = 24'd40; cfg_delay = 24'd2; cfg_mode = 32'h3F00;
    cfg_pkt = {16'd3, 16'd5}; cfg_null = 16'd2;
    cycles(1);
    enable = 1'b1;
    cycles(401);
    chk("R3", "frame_cnt after two frames", longint'(frame_cnt), 2);
    chk("R2", "line_start at frame boundary", longint'(line_start), 1);
    chk("R12", "line_cnt at frame boundary", longint'(line_cnt), 0);
    cycles(20);
    enable = 1'b0;
    cycles(3);
    // R1 ignored configuration while idle
    chk("R1", "running after enable low", longint'(running), 0);
    chk("R1", "frame_cnt cleared", longint'(frame_cnt), 0);

    // R4 sync-events mode: hsa field ignored, vbp skipped, single chunk, mixed lp (R11)
    run_cfg("R4 events", vbw(2, 0, 1), 12'd2, {16'd9, 16'd4}, 30, 0,
            32'h2A01, {16'd1, 16'd6}, 16'd4, 300);
    // R8 burst mode, chunk count ignored
    run_cfg("R8 burst", vbw(1, 1, 1), 12'd2, {16'd2, 16'd1}, 25, 3,
            32'h1502, {16'd4, 16'd4}, 16'd3, 260);
    // R8 reserved mode code also burst
    run_cfg("R8 mode3", vbw(0, 1, 0), 12'd1, {16'd1, 16'd1}, 25, 1,
            32'h3F03, {16'd4, 16'd4}, 16'd3, 100);
    // R8 chunk count zero in non-burst
    run_cfg("R8 zero chunks", vbw(1, 0, 0), 12'd2, {16'd2, 16'd2}, 20, 0,
            32'h0C00, {16'd0, 16'd5}, 16'd7, 130);
    // R7 back-to-back chunks without filler
    run_cfg("R7 no filler", vbw(0, 0, 1), 12'd2, {16'd1, 16'd1}, 30, 1,
            32'h3000, {16'd4, 16'd3}, 16'd0, 200);
    // R9 filler saturation at 1023
    run_cfg("R9 saturate", vbw(1, 0, 0), 12'd1, {16'd2, 16'd2}, 2100, 1,
            32'h3F00, {16'd2, 16'd3}, 16'd2000, 4300);
    // R10 payload cut at line end, hsa of 0 taken as 1
    run_cfg("R10 truncate", vbw(0, 0, 1), 12'd2, {16'd0, 16'd2}, 20, 1,
            32'h3800, {16'd1, 16'd30}, 16'd0, 130);
    // R2 zero line length and empty frame
    run_cfg("R2 degenerate", 32'd0, 12'd0, 32'd0, 0, 0,
            32'h0400, 32'd0, 16'd0, 20);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    done = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired (%s)", tag);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule